// File: doc/BRIEF.md
# Timer Access Trap Decoder

This block sits beside the system-register access path of a processor core and rules on every access to the generic timer and counter registers. For each access it weighs the current privilege level, whether the hypervisor level is enabled, the two host-mode flags, the three nested-virtualization flags and the fields of the hypervisor timer control register. From these it asserts exactly one outcome: allow, trap to the hypervisor with a syndrome class, or undefined.

The block also holds the hypervisor timer control register. Only the low 20 bits are live. In the non-host layout, bits 11:8 are held away from writes and read as zero. A kernel-level alias encoding of the register is redirected to the hypervisor register when it is used at level 2 in host mode, and a select output reports that redirect.

The decision logic is purely combinational. Only the control register is clocked.

Top module: `tmr_acc_gate`

## Requirements
- R1: After reset the control register reads all zero. Bits 63:20 of `ctl_rdata` always read 0, and write data on those bits is ignored.
- R2: Access class codes are 0 physical counter, 1 virtual counter, 2 physical timer, 3 virtual timer, 4 frequency, 5 nested-alias physical timer, 6 nested-alias virtual timer, 7 hypervisor control register, and 8 kernel control alias. Codes 9 to 15 are undefined. While `acc_valid` is high, exactly one of allow/trap/undef is high, and undefined takes priority over trap, which takes priority over allow. While `acc_valid` is low, all outcomes and `redir_hyp` are low.
- R3: Class 7 is undefined at level 0. At level 1 it traps when `hyp_en` and `nest_flags[0]` are both 1, and is undefined otherwise. At levels 2 and 3 it is allowed. An allowed write is visible on `ctl_rdata` from the next cycle, and a trapped or undefined write leaves the register unchanged.
- R4: Class 8 is undefined at level 0. At level 2 with `host_kern`=1 it is allowed, `redir_hyp` is 1, and a write updates the hypervisor register. In every other case `redir_hyp` is 0 and the hypervisor register is unchanged.
- R5: With `host_kern`=1 and `trap_gen`=0, a level 0/1 physical-timer access traps when bit 11 is 0, and a physical-counter access traps when bit 10 is 0.
- R6: With `host_kern`=1 and `trap_gen`=1, only level 0 is affected. Bit 9 clear traps the physical timer, bit 8 clear traps the virtual timer, bit 0 clear traps the physical counter, and bit 1 clear traps the virtual counter. The frequency register traps when bit 0 or bit 1 is clear. Bits 11 and 10 have no effect.
- R7: Bit 13 set traps level 0/1 virtual-timer accesses unless {`host_kern`,`trap_gen`} = {1,1}. Bit 14 set traps level 0/1 virtual-counter accesses unless `trap_gen`=1.
- R8: Classes 5 and 6 are undefined at level 0. At level 1 they trap when bit 15 (class 5) or bit 16 (class 6) is set, `nest_flags`[2:0] = 3'b101, and `trap_gen`=0. Otherwise they are allowed.
- R9: With `host_kern`=0, bits 11:8 read as 0 and writes to them are ignored, so the stored value is kept. A level 0/1 physical-timer access traps when bit 1 is 0, and a physical-counter access traps when bit 0 is 0.
- R10: With `hyp_en`=0 nothing traps. Timer and counter accesses at level 2 or 3 never trap.
- R11: A trap reports syndrome class 6'h18 on `trap_syn`. Otherwise `trap_syn` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_lvl | input | 2 | Current privilege level, 0 to 3 |
| hyp_en | input | 1 | Hypervisor level enabled in the current security state |
| host_kern | input | 1 | Host-kernel flag; selects the host register layout |
| trap_gen | input | 1 | Trap-general flag |
| nest_flags | input | 3 | Nested-virtualization flags {NV2, NV1, NV} |
| acc_class | input | 4 | Access class code (see R2) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | CTL_W (64) | Write data for the control register |
| acc_allow | output | 1 | Access is permitted |
| acc_trap | output | 1 | Access traps to the hypervisor |
| acc_undef | output | 1 | Access is undefined |
| trap_syn | output | 6 | Syndrome class of a trap |
| redir_hyp | output | 1 | Kernel alias is redirected to the hypervisor register |
| ctl_rdata | output | CTL_W (64) | Control register as seen in the current layout |

## Verification
Allow, trap, undef, syndrome and redirect are combinational in the access inputs, so they are due in the same cycle the access is presented. A control register write shows on `ctl_rdata` from the following cycle, because it passes through one register. The driver applies each access just after a rising edge and queues its expected outcome together with the register view from before that access. The monitor pops one item at each falling edge. This way outcomes are compared within the cycle, and the effect of a write is compared on the next queued item.

// File: rtl/tmr_acc_pkg.sv
// Shared types and constants for the timer access trap decoder.
// Assumes the control register has at most 32 live bits and that the
// field positions below are fixed by the software-visible layout.
package tmr_acc_pkg;

    localparam int CTL_W_DEF  = 64;
    localparam int LIVE_W_DEF = 20;
    localparam int SYN_W      = 6;

    // access class codes presented by the decode stage
    typedef enum logic [3:0] {
        AC_PCNT  = 4'd0,
        AC_VCNT  = 4'd1,
        AC_PTMR  = 4'd2,
        AC_VTMR  = 4'd3,
        AC_FREQ  = 4'd4,
        AC_NPTMR = 4'd5,
        AC_NVTMR = 4'd6,
        AC_HCTL  = 4'd7,
        AC_KCTL  = 4'd8
    } acc_cls_e;

    // control field positions (layout-dependent meaning)
    localparam int F_NEST_VT = 16;
    localparam int F_NEST_PT = 15;
    localparam int F_VCNT_TR = 14;
    localparam int F_VTMR_TR = 13;
    localparam int F_L1_PTEN = 11;
    localparam int F_L1_PCEN = 10;
    localparam int F_L0_PTEN = 9;
    localparam int F_L0_VTEN = 8;
    localparam int F_VCNT_EN = 1;   // host: level0 virt counter; non-host: phys timer
    localparam int F_PCNT_EN = 0;   // host: level0 phys counter; non-host: phys counter

    localparam int HOLE_LO = 8;
    localparam int HOLE_HI = 11;

    localparam logic [SYN_W-1:0] SYN_SYSACC   = 6'h18;
    localparam logic [2:0]       NEST_TRAP_PAT = 3'b101;

endpackage

// File: rtl/tmr_ctl_reg.sv
// Hypervisor timer control register.
// Holds LIVE_W bits; bits above read zero. In the non-host layout the hole
// bits keep their stored value on a write and read as zero.
// Assumes: we is already qualified by the access decision.
module tmr_ctl_reg
    import tmr_acc_pkg::*;
#(
    parameter int CTL_W  = CTL_W_DEF,
    parameter int LIVE_W = LIVE_W_DEF,
    parameter logic [LIVE_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              host,
    input  logic [CTL_W-1:0]  wdata,
    output logic [LIVE_W-1:0] fields,
    output logic [CTL_W-1:0]  rdata
);

    localparam int HOLE_N = HOLE_HI - HOLE_LO + 1;
    localparam logic [LIVE_W-1:0] HOLE_MASK =
        ((LIVE_W'(1) << HOLE_N) - LIVE_W'(1)) << HOLE_LO;

    logic [LIVE_W-1:0] q;
    logic [LIVE_W-1:0] keep_mask;
    logic [LIVE_W-1:0] view;

    // pick which stored bits survive a write
    always_comb begin
        keep_mask = host ? '0 : HOLE_MASK;
    end

    // register update with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (we) begin
            q <= (wdata[LIVE_W-1:0] & ~keep_mask) | (q & keep_mask);
        end
    end

    // layout-dependent read view
    always_comb begin
        view = host ? q : (q & ~HOLE_MASK);
    end

    assign fields = q;

    generate
        if (CTL_W > LIVE_W) begin : g_pad
            logic unused_hi_bits;
            assign unused_hi_bits = ^wdata[CTL_W-1:LIVE_W];
            assign rdata = {{(CTL_W-LIVE_W){1'b0}}, view};
        end else begin : g_full
            assign rdata = view;
        end
    endgenerate

endmodule

// File: rtl/tmr_trap_eval.sv
// Trap condition evaluator.
// Combinational: from the context flags, access class and the stored
// control fields, decide whether the access requests a trap to the
// hypervisor. Assumes the undefined check is applied separately with
// higher priority.
module tmr_trap_eval
    import tmr_acc_pkg::*;
#(
    parameter int LIVE_W = LIVE_W_DEF
) (
    input  logic [1:0]        lvl,
    input  logic              hyp_en,
    input  logic              host,
    input  logic              tg,
    input  logic [2:0]        nest,
    input  acc_cls_e          cls,
    input  logic [LIVE_W-1:0] c,
    output logic              trap_req
);

    logic low_lvl;
    logic lvl0;
    logic lvl1;
    logic nest_hit;
    logic raw;
    logic unused_ctl;

    assign unused_ctl = ^{c[LIVE_W-1:F_NEST_VT+1], c[12], c[7:2]};

    // level and nesting qualifiers
    always_comb begin
        low_lvl  = (lvl <= 2'd1);
        lvl0     = (lvl == 2'd0);
        lvl1     = (lvl == 2'd1);
        nest_hit = lvl1 && !tg && (nest == NEST_TRAP_PAT);
    end

    // per-class trap condition
    always_comb begin
        raw = 1'b0;
        unique case (cls)
            AC_PCNT:  raw = host ? (tg ? (lvl0 && !c[F_PCNT_EN])
                                       : (low_lvl && !c[F_L1_PCEN]))
                                 : (low_lvl && !c[F_PCNT_EN]);
            AC_VCNT:  raw = (low_lvl && c[F_VCNT_TR] && !tg)
                          || (host && tg && lvl0 && !c[F_VCNT_EN]);
            AC_PTMR:  raw = host ? (tg ? (lvl0 && !c[F_L0_PTEN])
                                       : (low_lvl && !c[F_L1_PTEN]))
                                 : (low_lvl && !c[F_VCNT_EN]);
            AC_VTMR:  raw = (low_lvl && c[F_VTMR_TR] && !(host && tg))
                          || (host && tg && lvl0 && !c[F_L0_VTEN]);
            AC_FREQ:  raw = host && tg && lvl0
                          && (!c[F_PCNT_EN] || !c[F_VCNT_EN]);
            AC_NPTMR: raw = nest_hit && c[F_NEST_PT];
            AC_NVTMR: raw = nest_hit && c[F_NEST_VT];
            AC_HCTL:  raw = lvl1 && nest[0];
            default:  raw = 1'b0;
        endcase
    end

    // hypervisor level gates every trap
    assign trap_req = hyp_en && raw;

endmodule

// File: rtl/tmr_acc_route.sv
// Register routing and undefined-encoding check.
// Combinational: flags encodings that are undefined at the current level,
// detects the kernel alias redirect and says whether the access targets the
// hypervisor control register. Assumes class codes from tmr_acc_pkg.
module tmr_acc_route
    import tmr_acc_pkg::*;
(
    input  logic [1:0] lvl,
    input  logic       hyp_en,
    input  logic       host,
    input  logic       nest_lo,
    input  acc_cls_e   cls,
    output logic       undef_req,
    output logic       redir,
    output logic       hits_hyp
);

    logic lvl0;
    logic lvl1;

    // level qualifiers
    always_comb begin
        lvl0 = (lvl == 2'd0);
        lvl1 = (lvl == 2'd1);
    end

    // undefined encodings per class and level
    always_comb begin
        undef_req = 1'b0;
        unique case (cls)
            AC_PCNT, AC_VCNT, AC_PTMR, AC_VTMR, AC_FREQ:
                undef_req = 1'b0;
            AC_NPTMR, AC_NVTMR, AC_KCTL:
                undef_req = lvl0;
            AC_HCTL:
                undef_req = lvl0 || (lvl1 && !(hyp_en && nest_lo));
            default:
                undef_req = 1'b1;
        endcase
    end

    // alias redirect and target selection
    always_comb begin
        redir    = (cls == AC_KCTL) && (lvl == 2'd2) && host;
        hits_hyp = (cls == AC_HCTL) || redir;
    end

endmodule

// File: rtl/tmr_acc_gate.sv
// Timer access trap decoder, top level.
// Combines the undefined check, trap evaluation and routing into one
// outcome per access (undef > trap > allow), and owns the control register.
// Assumes one access per cycle; outcomes are combinational.
module tmr_acc_gate
    import tmr_acc_pkg::*;
#(
    parameter int CTL_W  = CTL_W_DEF,
    parameter int LIVE_W = LIVE_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [1:0]       acc_lvl,
    input  logic             hyp_en,
    input  logic             host_kern,
    input  logic             trap_gen,
    input  logic [2:0]       nest_flags,
    input  logic [3:0]       acc_class,
    input  logic             acc_write,
    input  logic [CTL_W-1:0] acc_wdata,
    output logic             acc_allow,
    output logic             acc_trap,
    output logic             acc_undef,
    output logic [5:0]       trap_syn,
    output logic             redir_hyp,
    output logic [CTL_W-1:0] ctl_rdata
);

    acc_cls_e          cls;
    logic [LIVE_W-1:0] fields;
    logic              trap_req;
    logic              undef_req;
    logic              redir;
    logic              hits_hyp;
    logic              ctl_we;

    assign cls = acc_cls_e'(acc_class);

    tmr_trap_eval #(.LIVE_W(LIVE_W)) u_trap (
        .lvl      (acc_lvl),
        .hyp_en   (hyp_en),
        .host     (host_kern),
        .tg       (trap_gen),
        .nest     (nest_flags),
        .cls      (cls),
        .c        (fields),
        .trap_req (trap_req)
    );

    tmr_acc_route u_route (
        .lvl       (acc_lvl),
        .hyp_en    (hyp_en),
        .host      (host_kern),
        .nest_lo   (nest_flags[0]),
        .cls       (cls),
        .undef_req (undef_req),
        .redir     (redir),
        .hits_hyp  (hits_hyp)
    );

    // outcome priority: undefined, then trap, then allow
    always_comb begin
        acc_undef = acc_valid && undef_req;
        acc_trap  = acc_valid && !undef_req && trap_req;
        acc_allow = acc_valid && !undef_req && !trap_req;
        trap_syn  = acc_trap ? SYN_SYSACC : '0;
        redir_hyp = acc_valid && redir;
        ctl_we    = acc_allow && acc_write && hits_hyp;
    end

    tmr_ctl_reg #(.CTL_W(CTL_W), .LIVE_W(LIVE_W)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctl_we),
        .host   (host_kern),
        .wdata  (acc_wdata),
        .fields (fields),
        .rdata  (ctl_rdata)
    );

endmodule

// File: rtl/tmr_acc_gate_chk.sv
// Assertion checker for tmr_acc_gate, attached by bind.
// Watches only top-level ports.
module tmr_acc_gate_chk #(
    parameter int CTL_W  = 64,
    parameter int LIVE_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [1:0]       acc_lvl,
    input logic             hyp_en,
    input logic             host_kern,
    input logic [3:0]       acc_class,
    input logic             acc_write,
    input logic             acc_allow,
    input logic             acc_trap,
    input logic             acc_undef,
    input logic [5:0]       trap_syn,
    input logic             redir_hyp,
    input logic [CTL_W-1:0] ctl_rdata
);

    p_resv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[CTL_W-1:LIVE_W] == '0);

    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $countones({acc_allow, acc_trap, acc_undef}) == 1);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !(acc_allow || acc_trap || acc_undef || redir_hyp));

    p_ctl_lvl0_undef_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_lvl == 2'd0 && acc_class == 4'd7) |-> acc_undef);

    p_blocked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !acc_allow && host_kern)
        |=> (!host_kern || ctl_rdata == $past(ctl_rdata)));

    p_alias_redir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_class == 4'd8 && acc_lvl == 2'd2 && host_kern)
        |-> (redir_hyp && acc_allow));

    p_nohost_hole_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_kern |-> ctl_rdata[11:8] == 4'h0);

    p_no_trap_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hyp_en |-> !acc_trap);

    p_syn_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_trap |-> trap_syn == 6'h18);

    p_syn_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_trap |-> trap_syn == 6'h00);

endmodule

bind tmr_acc_gate tmr_acc_gate_chk #(.CTL_W(CTL_W), .LIVE_W(LIVE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_lvl   (acc_lvl),
    .hyp_en    (hyp_en),
    .host_kern (host_kern),
    .acc_class (acc_class),
    .acc_write (acc_write),
    .acc_allow (acc_allow),
    .acc_trap  (acc_trap),
    .acc_undef (acc_undef),
    .trap_syn  (trap_syn),
    .redir_hyp (redir_hyp),
    .ctl_rdata (ctl_rdata)
);

// File: tb/sim_tmr_acc_gate.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver queues expected results, the monitor
// pops one per cycle at the falling edge and compares.
module sim_tmr_acc_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_lvl = '0;
    logic        hyp_en = 1'b0;
    logic        host_kern = 1'b0;
    logic        trap_gen = 1'b0;
    logic [2:0]  nest_flags = '0;
    logic [3:0]  acc_class = '0;
    logic        acc_write = 1'b0;
    logic [63:0] acc_wdata = '0;
    logic        acc_allow, acc_trap, acc_undef, redir_hyp;
    logic [5:0]  trap_syn;
    logic [63:0] ctl_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // outcome codes used by the bench: 0 allow, 1 trap, 2 undef, 3 idle
    typedef struct {
        int          outc;
        int          redir;
        logic [63:0] rd;
        string       tag;
    } exp_t;
    exp_t sbq[$];
    logic [63:0] model = '0;

    always #2.5 clk = ~clk;

    tmr_acc_gate u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_lvl(acc_lvl),
        .hyp_en(hyp_en), .host_kern(host_kern), .trap_gen(trap_gen),
        .nest_flags(nest_flags), .acc_class(acc_class), .acc_write(acc_write),
        .acc_wdata(acc_wdata), .acc_allow(acc_allow), .acc_trap(acc_trap),
        .acc_undef(acc_undef), .trap_syn(trap_syn), .redir_hyp(redir_hyp),
        .ctl_rdata(ctl_rdata)
    );

    function automatic logic [63:0] view(input logic [63:0] m, input logic hk);
        return hk ? (m & 64'hFFFFF) : (m & 64'hFF0FF);
    endfunction

    task automatic ctx(input int hyp, input int hk, input int tg, input int nest);
        @(posedge clk); #1;
        acc_valid  = 1'b0;
        hyp_en     = 1'(hyp);
        host_kern  = 1'(hk);
        trap_gen   = 1'(tg);
        nest_flags = 3'(nest);
        sbq.push_back('{3, 0, view(model, 1'(hk)), "context"});
    endtask

    task automatic acc(input int lvl, input int cls, input int wr,
                       input logic [63:0] wd, input int outc, input int rdir,
                       input string tag);
        exp_t it;
        @(posedge clk); #1;
        acc_valid = 1'b1;
        acc_lvl   = 2'(lvl);
        acc_class = 4'(cls);
        acc_write = 1'(wr);
        acc_wdata = wd;
        it = '{outc, rdir, view(model, host_kern), tag};
        sbq.push_back(it);
        if (outc == 0 && wr != 0 && (cls == 7 || (cls == 8 && rdir != 0))) begin
            if (host_kern) model = wd & 64'hFFFFF;
            else           model = (wd & 64'hFF0FF) | (model & 64'h00F00);
        end
    endtask

    task automatic idle(input string tag);
        @(posedge clk); #1;
        acc_valid = 1'b0;
        acc_write = 1'b0;
        sbq.push_back('{3, 0, view(model, host_kern), tag});
    endtask

    // monitor: compare one queued item per cycle
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            logic [9:0] act, expv;
            e = sbq.pop_front();
            expv = {e.outc == 0, e.outc == 1, e.outc == 2, 1'(e.redir),
                    (e.outc == 1) ? 6'h18 : 6'h00};
            act  = {acc_allow, acc_trap, acc_undef, redir_hyp, trap_syn};
            checks++;
            if (act !== expv || ctl_rdata !== e.rd) begin
                failures++;
                $display("FAIL %s: outcome act=%b exp=%b rdata act=%h exp=%h",
                         e.tag, act, expv, ctl_rdata, e.rd);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle("R1 reset value");
        ctx(1, 1, 0, 0);
        acc(2, 7, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R3 level2 write");
        idle("R1 upper bits ignored");
        acc(1, 2, 0, 0, 0, 0, "R5 bit11 set allows");
        acc(3, 7, 1, 64'h0, 0, 0, "R3 level3 write");
        acc(1, 2, 0, 0, 1, 0, "R5 ptmr trap");
        acc(0, 0, 0, 0, 1, 0, "R5 pcnt trap");
        acc(2, 2, 0, 0, 0, 0, "R10 level2 no trap");
        ctx(0, 1, 0, 0);
        acc(1, 2, 0, 0, 0, 0, "R10 hyp disabled");
        ctx(1, 1, 1, 0);
        acc(0, 2, 0, 0, 1, 0, "R6 bit9 clear");
        acc(1, 2, 0, 0, 0, 0, "R6 level1 unaffected");
        acc(0, 4, 0, 0, 1, 0, "R6 freq trap");
        acc(0, 3, 0, 0, 1, 0, "R6 bit8 clear");
        acc(2, 7, 1, 64'h1, 0, 0, "R3 write");
        acc(0, 0, 0, 0, 0, 0, "R6 bit0 set");
        acc(0, 4, 0, 0, 1, 0, "R6 freq needs bit1");
        acc(0, 1, 0, 0, 1, 0, "R6 bit1 clear");
        acc(2, 7, 1, 64'h6303, 0, 0, "R3 write");
        acc(0, 2, 0, 0, 0, 0, "R6 bit9 set");
        acc(0, 3, 0, 0, 0, 0, "R7 host exempt vtmr");
        acc(0, 1, 0, 0, 0, 0, "R7 tg exempt vcnt");
        acc(0, 4, 0, 0, 0, 0, "R6 freq allowed");
        ctx(1, 1, 0, 0);
        acc(2, 7, 1, 64'h6C00, 0, 0, "R3 write");
        acc(1, 3, 0, 0, 1, 0, "R7 bit13 trap");
        acc(0, 1, 0, 0, 1, 0, "R7 bit14 trap");
        acc(1, 2, 0, 0, 0, 0, "R5 bit11 set");
        ctx(1, 0, 1, 0);
        acc(1, 3, 0, 0, 1, 0, "R7 nonhost tg vtmr trap");
        acc(1, 1, 0, 0, 0, 0, "R7 tg vcnt exempt");
        ctx(1, 1, 0, 0);
        acc(2, 7, 1, 64'h18000, 0, 0, "R3 write");
        ctx(1, 1, 0, 5);
        acc(1, 6, 0, 0, 1, 0, "R8 nested vtmr trap");
        acc(1, 5, 0, 0, 1, 0, "R8 nested ptmr trap");
        acc(0, 5, 0, 0, 2, 0, "R8 level0 undef");
        acc(2, 6, 0, 0, 0, 0, "R8 level2 allow");
        ctx(1, 1, 0, 7);
        acc(1, 6, 0, 0, 0, 0, "R8 wrong pattern");
        ctx(1, 1, 1, 5);
        acc(1, 5, 0, 0, 0, 0, "R8 tg set");
        ctx(1, 1, 0, 1);
        acc(1, 7, 1, 64'hABC, 1, 0, "R3 level1 trap");
        acc(0, 7, 0, 0, 2, 0, "R3 level0 undef");
        ctx(1, 1, 0, 0);
        acc(1, 7, 1, 64'h5, 2, 0, "R3 level1 undef");
        ctx(0, 1, 0, 1);
        acc(1, 7, 0, 0, 2, 0, "R3 hyp off undef");
        ctx(1, 1, 0, 0);
        acc(2, 8, 1, 64'h5, 0, 1, "R4 redirect write");
        idle("R4 redirected value");
        ctx(1, 0, 0, 0);
        acc(2, 8, 1, 64'hAA, 0, 0, "R4 no redirect");
        idle("R4 register unchanged");
        acc(1, 8, 0, 0, 0, 0, "R4 level1 kernel");
        acc(0, 8, 0, 0, 2, 0, "R4 level0 undef");
        acc(2, 12, 0, 0, 2, 0, "R2 unknown class");
        ctx(1, 1, 0, 0);
        acc(2, 7, 1, 64'hF03, 0, 0, "R3 write");
        idle("R9 host view");
        ctx(1, 0, 0, 0);
        idle("R9 hole reads zero");
        acc(2, 7, 1, 64'h0, 0, 0, "R9 nonhost write");
        idle("R9 view after write");
        ctx(1, 1, 0, 0);
        idle("R9 hole kept");
        ctx(1, 0, 0, 0);
        acc(1, 2, 0, 0, 1, 0, "R9 bit1 clear");
        acc(0, 0, 0, 0, 1, 0, "R9 bit0 clear");
        acc(2, 7, 1, 64'h3, 0, 0, "R9 enable write");
        acc(1, 2, 0, 0, 0, 0, "R9 bit1 set");
        acc(0, 0, 0, 0, 0, 0, "R9 bit0 set");
        idle("R2 idle quiet");
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule